// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Status Flags

This block is a byte-oriented serial peripheral interface controller reached through a small register interface. The interface has three registers: control, status and data. Software sets the mode, the interrupt enable and the clock rate in the control register. In master mode, writing a byte to the data register starts a transfer. The block derives the serial clock from the system clock through a divider and exchanges eight bits, most significant bit first, in SPI mode 0.

When a transfer ends, the received byte becomes readable and a completion flag sets. This flag drives an interrupt request through the interrupt-enable bit and a global enable input. A second flag records a data write that arrived while a transfer was running. Both flags clear in one of two ways: an acknowledge pulse, or a status read that sees a flag followed by an access to the data register.

While in master mode, the slave-select input is watched as a fault source when it is configured as an input. Pulling it low drops the block out of master mode. In slave mode, an external serial clock is brought in through a synchroniser and the block exchanges a preloaded byte with the remote master.

Top module: `spi_ctl`

## Requirements
- R1: After reset, reads of the control (address 0), status (address 1) and data (address 2) registers return 0x00, and both `irq` and `sck_o` are low.
- R2: In master mode the serial clock runs at the system clock divided by N, and the completion flag becomes visible exactly 8·N cycles after the cycle that writes the data register. With the double-speed bit at 0, rate codes 0, 1, 2 and 3 give N = 4, 16, 64 and 128. With the double-speed bit at 1 they give N = 2, 8, 32 and 64.
- R3: A master transfer drives `sdo` most significant bit first, holding each bit across the rising edge of `sck_o`. It samples `sdi` on each rising edge, keeps `sck_o` low when idle, and makes the received byte readable at the data register when the completion flag sets.
- R4: Status register layout: bit 7 is the completion flag and bit 6 is the collision flag, both read-only. Bit 0 is the double-speed bit, which can be read and written. Bits 5..1 always read as zero.
- R5: `irq` is high exactly while the completion flag, control bit 7 (interrupt enable) and `glob_ie` are all set.
- R6: A one-cycle pulse on `irq_ack` clears the completion flag.
- R7: A status read that sees a set flag arms a clear. The next data register access (read or write) then clears the completion flag, and it also clears the collision flag if that flag was seen set. Reads of the control register in between do not disarm the clear. A data register access without a prior arming read leaves the flags unchanged.
- R8: A data register write while a transfer is running sets the collision flag and is discarded. The byte being shifted completes unchanged.
- R9: When control bits 6 (enable) and 4 (master) are set, `ss_is_input` is high and the synchronised `ss_n` is low, the completion flag sets, control bit 4 is cleared and any master transfer is aborted, with `sck_o` returning low.
- R10: In slave mode (enable set, master clear, `ss_n` low), `sck_i`, `sdi` and `ss_n` are synchronised. The block samples `sdi` on each synchronised rising edge of `sck_i` and shifts out the preloaded byte most significant bit first. It sets the completion flag on the eighth rising edge. The rate code and the double-speed bit have no effect in this mode.
- R11: A flag-setting event (completion, fault or collision) in the same cycle as a clearing access or an acknowledge leaves that flag set.
- R12: Control register layout: bit 7 is the interrupt enable, bit 6 is the block enable, bit 4 selects master mode, and bits 1..0 hold the rate code. Bits 5, 3 and 2 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for the selected address |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ss_n | input | 1 | Slave-select level, active low |
| ss_is_input | input | 1 | Slave-select pin is configured as an input |

## Verification
A transfer can complete in the very cycle that the armed clearing access reaches the data register, so the completion set and the flag clear land together. The bench provokes this with the fastest rate. It issues a colliding write, then a status read that sees the collision flag, and times a data register read to fall exactly 16 cycles after the starting write. It then expects the completion flag to remain set while the collision flag is gone, and expects the byte read afterwards to be the original, not the colliding one.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam int DIV_W = 7;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_DATA = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       master;
    logic [1:0] rate;
  } ctrl_t;

  // Half-period of the serial clock minus one, in system clock cycles.
  function automatic logic [DIV_W-1:0] half_limit(input logic dbl, input logic [1:0] rate);
    int lg;
    lg = (rate == 2'd3) ? 6 : (2 * int'(rate) + 1);
    lg = lg - int'(dbl);
    return DIV_W'((1 << lg) - 1);
  endfunction

endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[i] <= RST;
        end else if (i == 0) begin
          stg_q[i] <= d;
        end else begin
          stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master
  import spi_ctl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [DW-1:0]    load_data,
  input  logic [DIV_W-1:0] half_lim,
  input  logic             sdi,
  output logic             busy,
  output logic             sck,
  output logic             sdo,
  output logic             done,
  output logic [DW-1:0]    rx
);

  localparam int            EW        = $clog2(2 * DW);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);

  logic             busy_q, busy_d;
  logic             sck_q, sck_d;
  logic             samp_q, samp_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [EW-1:0]    edge_q, edge_d;
  logic             tick, last;

  always_comb begin
    tick   = busy_q && (cnt_q == half_lim);
    last   = tick && sck_q && (edge_q == LAST_EDGE);
    busy_d = busy_q;
    sck_d  = sck_q;
    samp_d = samp_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    edge_d = edge_q;
    if (abort) begin
      busy_d = 1'b0;
      sck_d  = 1'b0;
      cnt_d  = '0;
      edge_d = '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = load_data;
        cnt_d  = '0;
        edge_d = '0;
        sck_d  = 1'b0;
      end
    end else if (tick) begin
      cnt_d  = '0;
      edge_d = edge_q + 1'b1;
      sck_d  = ~sck_q;
      if (!sck_q) begin
        samp_d = sdi;
      end else begin
        sh_d = {sh_q[DW-2:0], samp_q};
      end
      if (last) begin
        busy_d = 1'b0;
        sck_d  = 1'b0;
        edge_d = '0;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      edge_q <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      samp_q <= samp_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      edge_q <= edge_d;
    end
  end

  assign busy = busy_q;
  assign sck  = sck_q;
  assign sdo  = sh_q[DW-1];
  assign done = last && !abort;
  assign rx   = {sh_q[DW-2:0], samp_q};

endmodule

// File: rtl/spi_ctl_slave.sv
module spi_ctl_slave #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sck_s,
  input  logic          sdi_s,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          busy,
  output logic          sdo,
  output logic          done,
  output logic [DW-1:0] rx
);

  localparam int            CW       = $clog2(DW);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic          prev_q, prev_d;
  logic          samp_q, samp_d;
  logic          tail_q, tail_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise, fall;

  always_comb begin
    rise   = sel && sck_s && !prev_q;
    fall   = sel && !sck_s && prev_q;
    prev_d = sck_s;
    samp_d = samp_q;
    tail_d = tail_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    if (!sel) begin
      cnt_d  = '0;
      tail_d = 1'b0;
    end else begin
      if (rise) begin
        samp_d = sdi_s;
        if (cnt_q == LAST_BIT) begin
          cnt_d  = '0;
          tail_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (fall) begin
        sh_d   = {sh_q[DW-2:0], samp_q};
        tail_d = 1'b0;
      end
    end
    if (load) begin
      sh_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      samp_q <= 1'b0;
      tail_q <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      samp_q <= samp_d;
      tail_q <= tail_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = sel && ((cnt_q != '0) || tail_q);
  assign sdo  = sh_q[DW-1];
  assign done = rise && (cnt_q == LAST_BIT);
  assign rx   = {sh_q[DW-2:0], sdi_s};

endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          glob_ie,
  input  logic          irq_ack,
  output logic          irq,
  output logic          sck_o,
  input  logic          sck_i,
  output logic          sdo,
  input  logic          sdi,
  input  logic          ss_n,
  input  logic          ss_is_input
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic ss_s, sck_s, sdi_s;

  spi_ctl_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST    (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({ss_n, sck_i, sdi}),
    .q     ({ss_s, sck_s, sdi_s})
  );

  reg_addr_e addr_e;
  logic      wr_ctrl, wr_stat, wr_data, rd_stat, data_acc;

  ctrl_t         ctrl_q, ctrl_d;
  logic          dbl_q, dbl_d;
  logic          spif_q, spif_d;
  logic          wcol_q, wcol_d;
  logic          arm_q, arm_d;
  logic          arm_col_q, arm_col_d;
  logic [DW-1:0] rx_buf_q, rx_buf_d;

  logic          m_busy, m_done, m_sdo, m_start, m_abort, m_sck;
  logic [DW-1:0] m_rx;
  logic          s_busy, s_done, s_sdo, s_sel, s_load;
  logic [DW-1:0] s_rx;
  logic          xfer_busy, fault, collide, data_wr_ok;

  always_comb begin
    addr_e     = reg_addr_e'(addr);
    wr_ctrl    = wr_en && (addr_e == ADR_CTRL);
    wr_stat    = wr_en && (addr_e == ADR_STAT);
    wr_data    = wr_en && (addr_e == ADR_DATA);
    rd_stat    = rd_en && (addr_e == ADR_STAT);
    data_acc   = (wr_en || rd_en) && (addr_e == ADR_DATA);
    xfer_busy  = m_busy || s_busy;
    fault      = ctrl_q.enable && ctrl_q.master && ss_is_input && !ss_s;
    m_abort    = fault || !ctrl_q.enable || !ctrl_q.master;
    data_wr_ok = wr_data && !xfer_busy;
    collide    = wr_data && xfer_busy;
    m_start    = data_wr_ok && ctrl_q.enable && ctrl_q.master && !fault;
    s_load     = data_wr_ok;
    s_sel      = ctrl_q.enable && !ctrl_q.master && !ss_s;
  end

  spi_ctl_master #(.DW(DW)) u_master (
    .clk       (clk),
    .rst_n     (rst_i),
    .start     (m_start),
    .abort     (m_abort),
    .load_data (wdata),
    .half_lim  (half_limit(dbl_q, ctrl_q.rate)),
    .sdi       (sdi),
    .busy      (m_busy),
    .sck       (m_sck),
    .sdo       (m_sdo),
    .done      (m_done),
    .rx        (m_rx)
  );

  spi_ctl_slave #(.DW(DW)) u_slave (
    .clk       (clk),
    .rst_n     (rst_i),
    .sel       (s_sel),
    .sck_s     (sck_s),
    .sdi_s     (sdi_s),
    .load      (s_load),
    .load_data (wdata),
    .busy      (s_busy),
    .sdo       (s_sdo),
    .done      (s_done),
    .rx        (s_rx)
  );

  // Next state of the register file and flags.
  always_comb begin
    ctrl_d    = ctrl_q;
    dbl_d     = dbl_q;
    spif_d    = spif_q;
    wcol_d    = wcol_q;
    arm_d     = arm_q;
    arm_col_d = arm_col_q;
    rx_buf_d  = rx_buf_q;

    if (wr_ctrl) begin
      ctrl_d.irq_en = wdata[7];
      ctrl_d.enable = wdata[6];
      ctrl_d.master = wdata[4];
      ctrl_d.rate   = wdata[1:0];
    end
    if (fault) begin
      ctrl_d.master = 1'b0;
    end
    if (wr_stat) begin
      dbl_d = wdata[0];
    end

    if (m_done) begin
      rx_buf_d = m_rx;
    end else if (s_done) begin
      rx_buf_d = s_rx;
    end

    // Arming on a status read that observes a flag.
    if (rd_stat && (spif_q || wcol_q)) begin
      arm_d = 1'b1;
      if (wcol_q) begin
        arm_col_d = 1'b1;
      end
    end

    // Clearing access to the data register.
    if (data_acc && arm_q) begin
      spif_d    = 1'b0;
      arm_d     = 1'b0;
      arm_col_d = 1'b0;
      if (arm_col_q) begin
        wcol_d = 1'b0;
      end
    end
    if (irq_ack) begin
      spif_d = 1'b0;
    end

    // Set events take priority over clears.
    if (m_done || s_done || fault) begin
      spif_d = 1'b1;
    end
    if (collide) begin
      wcol_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q    <= '0;
      dbl_q     <= 1'b0;
      spif_q    <= 1'b0;
      wcol_q    <= 1'b0;
      arm_q     <= 1'b0;
      arm_col_q <= 1'b0;
      rx_buf_q  <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      dbl_q     <= dbl_d;
      spif_q    <= spif_d;
      wcol_q    <= wcol_d;
      arm_q     <= arm_d;
      arm_col_q <= arm_col_d;
      rx_buf_q  <= rx_buf_d;
    end
  end

  always_comb begin
    case (addr_e)
      ADR_CTRL: rdata = DW'({ctrl_q.irq_en, ctrl_q.enable, 1'b0, ctrl_q.master, 2'b00, ctrl_q.rate});
      ADR_STAT: rdata = DW'({spif_q, wcol_q, 5'b00000, dbl_q});
      ADR_DATA: rdata = rx_buf_q;
      default:  rdata = '0;
    endcase
  end

  assign irq   = spif_q && ctrl_q.irq_en && glob_ie;
  assign sck_o = m_sck;
  assign sdo   = ctrl_q.master ? m_sdo : s_sdo;

endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       irq_ack,
  input logic       m_busy,
  input logic       s_busy,
  input logic       m_done,
  input logic       s_done,
  input logic       fault,
  input logic       spif_q,
  input logic       wcol_q,
  input logic       mst,
  input logic       sck_o
);

  a_r8_collide_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && (m_busy || s_busy)) |=> wcol_q);

  a_r9_fault_leaves_master: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!mst && !m_busy));

  a_r3_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (m_done || s_done) |=> spif_q);

  a_r3_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy |-> !sck_o);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !m_done && !s_done && !fault) |=> !spif_q);

  a_r10_one_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_busy, s_busy}));

endmodule

bind spi_ctl spi_ctl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_i),
  .wr_en   (wr_en),
  .addr    (addr),
  .irq_ack (irq_ack),
  .m_busy  (m_busy),
  .s_busy  (s_busy),
  .m_done  (m_done),
  .s_done  (s_done),
  .fault   (fault),
  .spif_q  (spif_q),
  .wcol_q  (wcol_q),
  .mst     (ctrl_q.master),
  .sck_o   (sck_o)
);

// File: tb/spi_ctl_bench.sv
module spi_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       glob_ie = 1'b1;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       sck_o;
  logic       sck_i = 1'b0;
  logic       sdo;
  logic       sdi;
  logic       ss_n = 1'b1;
  logic       ss_is_input = 1'b0;
  logic       loop_en = 1'b1;
  logic       sdi_drv = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] cap = 8'h00;

  assign sdi = loop_en ? sdo : sdi_drv;

  always #10 clk = ~clk;

  always @(posedge sck_o) cap = {cap[6:0], sdo};

  spi_ctl u_spi_ctl (
    .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en), .rd_en (rd_en),
    .wdata (wdata), .rdata (rdata), .glob_ie (glob_ie), .irq_ack (irq_ack),
    .irq (irq), .sck_o (sck_o), .sck_i (sck_i), .sdo (sdo), .sdi (sdi),
    .ss_n (ss_n), .ss_is_input (ss_is_input)
  );

  function automatic int exp_div(input logic dbl, input logic [1:0] rate);
    int n;
    case (rate)
      2'd0: n = 4;
      2'd1: n = 16;
      2'd2: n = 64;
      default: n = 128;
    endcase
    return dbl ? n / 2 : n;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #2 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic slave_xfer(input logic [1:0] rate, input logic dbl,
                            input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got;
    logic [7:0] seen;
    seen = 8'h00;
    loop_en = 1'b0;
    bus_wr(2'd1, {7'd0, dbl});
    bus_wr(2'd0, {2'b11, 4'b0000, rate});
    bus_wr(2'd2, tx);
    ss_n = 1'b0;
    idle(4);
    for (int i = 0; i < 8; i++) begin
      sdi_drv = rx[7-i];
      idle(4);
      seen = {seen[6:0], sdo};
      sck_i = 1'b1;
      idle(4);
      sck_i = 1'b0;
    end
    idle(6);
    chk("R10 slave flag", {7'd0, irq}, 8'h01);
    bus_rd(2'd2, got);
    chk("R10 slave rx byte", got, rx);
    chk("R10 slave tx MSB first", seen, tx);
    ack();
    ss_n = 1'b1;
    idle(4);
  endtask

  initial begin
    logic [7:0] v;
    logic [1:0] rate;
    logic       dbl;
    logic [7:0] tx;
    logic       bitv;
    int         n;
    v = 8'($urandom(32'h5EED_1234));

    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    bus_rd(2'd1, v); chk("R1 stat reset", v, 8'h00);
    bus_rd(2'd2, v); chk("R1 data reset", v, 8'h00);
    chk("R1 irq/sck reset", {6'd0, irq, sck_o}, 8'h00);

    // R12 control layout, R4 status layout
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, v); chk("R12 ctrl layout", v, 8'hD3);
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, v); chk("R4 stat dbl set", v, 8'h01);
    bus_wr(2'd1, 8'hFE);
    bus_rd(2'd1, v); chk("R4 stat dbl clear", v, 8'h00);

    // R2/R3 directed: MSB-first shape at fastest rate
    loop_en = 1'b1;
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd0, 8'hD0);
    cap = 8'h00;
    bus_wr(2'd2, 8'hB4);
    idle(15);
    chk("R2 flag not early (N=2)", {7'd0, irq}, 8'h00);
    idle(1);
    chk("R2 flag on time (N=2)", {7'd0, irq}, 8'h01);
    chk("R3 sdo MSB first", cap, 8'hB4);
    chk("R3 sck idle low", {7'd0, sck_o}, 8'h00);
    bus_rd(2'd2, v); chk("R3 loopback rx", v, 8'hB4);

    // R7 unarmed data access leaves the flag
    chk("R7 unarmed access keeps flag", {7'd0, irq}, 8'h01);
    // R5 gating by global enable
    glob_ie = 1'b0; #1;
    chk("R5 irq gated by glob_ie", {7'd0, irq}, 8'h00);
    glob_ie = 1'b1;
    // R7 arm, intervening ctrl read, then clear
    bus_rd(2'd1, v); chk("R4 stat flag bit7", v, 8'h81);
    bus_rd(2'd0, v);
    chk("R7 ctrl read keeps flag", {7'd0, irq}, 8'h01);
    bus_rd(2'd2, v);
    chk("R7 armed access clears", {7'd0, irq}, 8'h00);

    // R8 + R11: collision, then armed read coinciding with completion
    bus_wr(2'd2, 8'h3C);
    bus_wr(2'd2, 8'h5A);
    bus_rd(2'd1, v); chk("R8 collision flag", v, 8'h41);
    idle(13);
    bus_rd(2'd2, v);
    chk("R11 set wins over clear", {7'd0, irq}, 8'h01);
    bus_rd(2'd1, v); chk("R11 wcol cleared spif kept", v, 8'h81);
    bus_rd(2'd2, v); chk("R8 discarded write", v, 8'h3C);
    chk("R7 clear after arm", {7'd0, irq}, 8'h00);

    // R6 acknowledge, R11 ack vs completion handled by set priority
    bus_wr(2'd2, 8'h11);
    idle(16);
    chk("R6 flag before ack", {7'd0, irq}, 8'h01);
    ack();
    chk("R6 ack clears", {7'd0, irq}, 8'h00);

    // R2/R3 random transfers
    for (int it = 0; it < 16; it++) begin
      dbl  = 1'($urandom);
      rate = 2'($urandom);
      tx   = 8'($urandom);
      bitv = 1'($urandom);
      loop_en = (it % 4 != 3);
      sdi_drv = bitv;
      n = exp_div(dbl, rate);
      bus_wr(2'd1, {7'd0, dbl});
      bus_wr(2'd0, {2'b11, 2'b01, 2'b00, rate});
      cap = 8'h00;
      bus_wr(2'd2, tx);
      idle(8 * n - 1);
      chk("R2 flag not early", {7'd0, irq}, 8'h00);
      idle(1);
      chk("R2 flag on time", {7'd0, irq}, 8'h01);
      chk("R3 sdo order", cap, tx);
      bus_rd(2'd2, v);
      chk("R3 received byte", v, loop_en ? tx : {8{bitv}});
      ack();
    end
    loop_en = 1'b1;

    // R9 slave-select fault
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'hD3);
    ss_is_input = 1'b1;
    bus_wr(2'd2, 8'hA5);
    idle(20);
    ss_n = 1'b0;
    idle(5);
    chk("R9 fault sets flag", {7'd0, irq}, 8'h01);
    bus_rd(2'd0, v); chk("R9 master bit cleared", v, 8'hC3);
    chk("R9 sck low after abort", {7'd0, sck_o}, 8'h00);
    ss_n = 1'b1;
    idle(4);
    ack();
    idle(1100);
    chk("R9 aborted transfer never completes", {7'd0, irq}, 8'h00);
    ss_is_input = 1'b0;

    // R10 slave mode, rate settings have no effect
    slave_xfer(2'd0, 1'b0, 8'hC6, 8'h39);
    slave_xfer(2'd3, 1'b1, 8'h5E, 8'hA7);
    bus_wr(2'd0, 8'h00);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule